// File: doc/BRIEF.md
# Borrowed-Register Incrementer

This block adds one to an (M+1)-bit target word. It uses M+1 helper wires whose contents it does not know in advance: a single carry wire and an M-bit scratch register. These helper wires are only borrowed. They may hold any value on entry, and they leave the network holding exactly the value they came in with. The network is reversible. Every stage is a NOT, a controlled NOT or a doubly controlled NOT acting on one shared wire bundle, and the number of stages grows linearly with M.

The increment is built by subtraction. A reversible ripple subtractor removes the carry and the scratch value from the target. The scratch register is then bit-inverted, the subtractor runs a second time, and the scratch register is inverted back. Taking away a value and then its complement leaves a +1, together with a stray flip of the target's top bit that a single NOT cancels. The carry still contributes minus two. This is removed by complementing the whole target, under control of the carry wire, at the very start and again at the very end. In the house two-process layout, the result of the combinational network is captured in an output register, so a result appears one clock after its inputs.

Top module: `inc_borrow_incr`

## Requirements
- R1: One clock edge after the inputs are sampled with reset released, `v_out` equals `v_in + 1` modulo 2^(M+1).
- R2: One clock edge after sampling, `c_out` equals the sampled `c_in`.
- R3: One clock edge after sampling, `g_out` equals the sampled `g_in`. Each subtractor pass on its own also leaves the scratch bits unchanged.
- R4: When every bit of `v_in` is 1, `v_out` becomes all zeros on the following edge.
- R5: For any fixed target and scratch value, the carry value 0 and the carry value 1 give the same `v_out`.
- R6: For any fixed target, every scratch value gives the same `v_out`.
- R7: While `rst_n` is low, all three outputs are 0. The clear is asynchronous and does not wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_in | input | M+1 | Target word to be incremented |
| c_in | input | 1 | Borrowed carry wire, any value |
| g_in | input | M | Borrowed scratch register, any value |
| v_out | output | M+1 | Registered incremented target |
| c_out | output | 1 | Registered carry wire, restored |
| g_out | output | M | Registered scratch register, restored |

## Verification
The assertions check on every clock the registered increment, the wrap from all-ones to zero, and the restoration of both borrowed inputs. They also check the arithmetic of each subtractor pass inside the network: the first pass must subtract the carry and scratch, the second must subtract the carry and the inverted scratch, and both must leave the scratch bits intact. Two things can only be shown by the bench's exhaustive sweep over every target, scratch and carry value: that the result is truly independent of the borrowed contents, and that reset clears the outputs asynchronously.

// File: rtl/inc_pkg.sv
package inc_pkg;

    // Kind of reversible stage applied to the wire bundle
    typedef enum logic [1:0] {
        GATE_NOT  = 2'd0,
        GATE_CNOT = 2'd1,
        GATE_TOF  = 2'd2
    } gate_e;

    // Bundle layout: carry wire at bit 0, scratch bits directly above it,
    // target bits above the scratch. The target base is 1 + M per instance.
    localparam int unsigned CARRY_POS = 0;
    localparam int unsigned SCR_BASE  = 1;

endpackage

// File: rtl/inc_gate.sv
module inc_gate #(
    parameter int unsigned   W    = 4,
    parameter inc_pkg::gate_e KIND = inc_pkg::GATE_NOT,
    parameter int unsigned   CA   = 0,
    parameter int unsigned   CB   = 0,
    parameter int unsigned   TGT  = 0
) (
    input  logic [W-1:0] s_i,
    output logic [W-1:0] s_o
);

    // One reversible stage: the target bit is toggled by a constant,
    // by one control or by the AND of two controls.
    logic flip;

    always_comb begin
        unique case (KIND)
            inc_pkg::GATE_CNOT: flip = s_i[CA];
            inc_pkg::GATE_TOF:  flip = s_i[CA] & s_i[CB];
            default:            flip = 1'b1;
        endcase
        s_o      = s_i;
        s_o[TGT] = s_i[TGT] ^ flip;
    end

endmodule

// File: rtl/inc_cflip.sv
module inc_cflip #(
    parameter int unsigned M = 8
) (
    input  logic [2*M+1:0] s_i,
    output logic [2*M+1:0] s_o
);

    localparam int unsigned W      = 2 * M + 2;
    localparam int unsigned V_BASE = inc_pkg::SCR_BASE + M;
    localparam int unsigned NV     = M + 1;

    // Chain of controlled NOTs: the carry wire complements every target bit
    logic [W-1:0] chain [0:NV];

    assign chain[0] = s_i;

    for (genvar j = 0; j < NV; j++) begin : g_bit
        inc_gate #(
            .W   (W),
            .KIND(inc_pkg::GATE_CNOT),
            .CA  (inc_pkg::CARRY_POS),
            .CB  (inc_pkg::CARRY_POS),
            .TGT (V_BASE + j)
        ) u_cnot (
            .s_i(chain[j]),
            .s_o(chain[j+1])
        );
    end

    assign s_o = chain[NV];

endmodule

// File: rtl/inc_ginv.sv
module inc_ginv #(
    parameter int unsigned M = 8
) (
    input  logic [2*M+1:0] s_i,
    output logic [2*M+1:0] s_o
);

    localparam int unsigned W = 2 * M + 2;

    // Plain NOT on every scratch bit
    logic [W-1:0] chain [0:M];

    assign chain[0] = s_i;

    for (genvar i = 0; i < M; i++) begin : g_bit
        inc_gate #(
            .W   (W),
            .KIND(inc_pkg::GATE_NOT),
            .CA  (0),
            .CB  (0),
            .TGT (inc_pkg::SCR_BASE + i)
        ) u_not (
            .s_i(chain[i]),
            .s_o(chain[i+1])
        );
    end

    assign s_o = chain[M];

endmodule

// File: rtl/inc_sub_pass.sv
module inc_sub_pass #(
    parameter int unsigned M = 8
) (
    input  logic [2*M+1:0] s_i,
    output logic [2*M+1:0] s_o
);

    // Reversible ripple subtractor: target := target - scratch - carry,
    // modulo 2^(M+1), with scratch and carry restored. It is the mirror
    // image of a majority / un-majority ripple adder.
    localparam int unsigned W       = 2 * M + 2;
    localparam int unsigned V_BASE  = inc_pkg::SCR_BASE + M;
    localparam int unsigned NG      = 6 * M + 1;
    localparam int unsigned MID     = 3 * M;

    logic [W-1:0] st [0:NG];

    assign st[0] = s_i;

    // Undo the un-majority stages, lowest bit first
    for (genvar i = 0; i < M; i++) begin : g_unuma
        localparam int unsigned XW = (i == 0) ? inc_pkg::CARRY_POS
                                              : inc_pkg::SCR_BASE + i - 1;
        localparam int unsigned YW = V_BASE + i;
        localparam int unsigned ZW = inc_pkg::SCR_BASE + i;
        localparam int unsigned K  = 3 * i;

        inc_gate #(.W(W), .KIND(inc_pkg::GATE_CNOT), .CA(XW), .CB(XW), .TGT(YW))
            u_g0 (.s_i(st[K]),   .s_o(st[K+1]));
        inc_gate #(.W(W), .KIND(inc_pkg::GATE_CNOT), .CA(ZW), .CB(ZW), .TGT(XW))
            u_g1 (.s_i(st[K+1]), .s_o(st[K+2]));
        inc_gate #(.W(W), .KIND(inc_pkg::GATE_TOF),  .CA(XW), .CB(YW), .TGT(ZW))
            u_g2 (.s_i(st[K+2]), .s_o(st[K+3]));
    end

    // Top target bit absorbs the borrow held on the highest scratch wire
    inc_gate #(
        .W   (W),
        .KIND(inc_pkg::GATE_CNOT),
        .CA  (inc_pkg::SCR_BASE + M - 1),
        .CB  (inc_pkg::SCR_BASE + M - 1),
        .TGT (V_BASE + M)
    ) u_top (
        .s_i(st[MID]),
        .s_o(st[MID+1])
    );

    // Undo the majority stages, highest bit first
    for (genvar r = 0; r < M; r++) begin : g_unmaj
        localparam int unsigned I  = M - 1 - r;
        localparam int unsigned XW = (I == 0) ? inc_pkg::CARRY_POS
                                              : inc_pkg::SCR_BASE + I - 1;
        localparam int unsigned YW = V_BASE + I;
        localparam int unsigned ZW = inc_pkg::SCR_BASE + I;
        localparam int unsigned K  = MID + 1 + 3 * r;

        inc_gate #(.W(W), .KIND(inc_pkg::GATE_TOF),  .CA(XW), .CB(YW), .TGT(ZW))
            u_g0 (.s_i(st[K]),   .s_o(st[K+1]));
        inc_gate #(.W(W), .KIND(inc_pkg::GATE_CNOT), .CA(ZW), .CB(ZW), .TGT(XW))
            u_g1 (.s_i(st[K+1]), .s_o(st[K+2]));
        inc_gate #(.W(W), .KIND(inc_pkg::GATE_CNOT), .CA(ZW), .CB(ZW), .TGT(YW))
            u_g2 (.s_i(st[K+2]), .s_o(st[K+3]));
    end

    assign s_o = st[NG];

endmodule

// File: rtl/inc_borrow_incr.sv
module inc_borrow_incr #(
    parameter int unsigned M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M:0]   v_in,
    input  logic         c_in,
    input  logic [M-1:0] g_in,
    output logic [M:0]   v_out,
    output logic         c_out,
    output logic [M-1:0] g_out
);

    localparam int unsigned W      = 2 * M + 2;
    localparam int unsigned V_BASE = inc_pkg::SCR_BASE + M;

    // Packed so that carry is bit 0, scratch above, target on top
    typedef struct packed {
        logic [M:0]   v;
        logic [M-1:0] g;
        logic         c;
    } wires_t;

    wires_t       res_d, res_q;

    logic [W-1:0] s_in;
    logic [W-1:0] s_flip;
    logic [W-1:0] s_pass1;
    logic [W-1:0] s_ginv1;
    logic [W-1:0] s_pass2;
    logic [W-1:0] s_ginv2;
    logic [W-1:0] s_fixtop;
    logic [W-1:0] s_done;

    assign s_in = {v_in, g_in, c_in};

    // Carry-controlled complement of the target, opening the sequence
    inc_cflip #(.M(M)) u_flip_head (.s_i(s_in), .s_o(s_flip));

    // First pass: subtract carry and scratch
    inc_sub_pass #(.M(M)) u_pass1 (.s_i(s_flip), .s_o(s_pass1));

    // Second pass runs on the inverted scratch register
    inc_ginv #(.M(M)) u_ginv_pre (.s_i(s_pass1), .s_o(s_ginv1));
    inc_sub_pass #(.M(M)) u_pass2 (.s_i(s_ginv1), .s_o(s_pass2));
    inc_ginv #(.M(M)) u_ginv_post (.s_i(s_pass2), .s_o(s_ginv2));

    // Cancel the toggle of the top target bit left by scratch + ~scratch
    inc_gate #(
        .W   (W),
        .KIND(inc_pkg::GATE_NOT),
        .CA  (0),
        .CB  (0),
        .TGT (V_BASE + M)
    ) u_fix_top (
        .s_i(s_ginv2),
        .s_o(s_fixtop)
    );

    // Carry-controlled complement closing the sequence
    inc_cflip #(.M(M)) u_flip_tail (.s_i(s_fixtop), .s_o(s_done));

    always_comb begin
        res_d = wires_t'(s_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign v_out = res_q.v;
    assign c_out = res_q.c;
    assign g_out = res_q.g;

endmodule

// File: rtl/inc_borrow_incr_chk.sv
module inc_borrow_incr_chk #(
    parameter int unsigned M = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [M:0]     v_in,
    input logic           c_in,
    input logic [M-1:0]   g_in,
    input logic [M:0]     v_out,
    input logic           c_out,
    input logic [M-1:0]   g_out,
    input logic [2*M+1:0] s_flip,
    input logic [2*M+1:0] s_pass1,
    input logic [2*M+1:0] s_pass2
);

    localparam int unsigned W = 2 * M + 2;
    localparam logic [M:0]  ONE_V = (M+1)'(1);

    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
        end
    end

    // Field views of the bundle around the two subtractor passes
    logic [M:0]   f_v, p1_v, p2_v;
    logic [M-1:0] f_g, p1_g, p2_g;
    logic         f_c, p1_c;

    assign f_v  = s_flip[W-1:M+1];
    assign f_g  = s_flip[M:1];
    assign f_c  = s_flip[0];
    assign p1_v = s_pass1[W-1:M+1];
    assign p1_g = s_pass1[M:1];
    assign p1_c = s_pass1[0];
    assign p2_v = s_pass2[W-1:M+1];
    assign p2_g = s_pass2[M:1];

    p_increment_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (v_out == $past(v_in) + ONE_V));

    p_carry_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (c_out == $past(c_in)));

    p_scratch_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (g_out == $past(g_in)));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(&v_in)) |-> (v_out == '0));

    // Supports R1: first pass removes carry and scratch from the target
    p_pass1_sub_r1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_v == f_v - {1'b0, f_g} - {{M{1'b0}}, f_c});

    // Supports R1: second pass removes carry and the inverted scratch
    p_pass2_sub_r1: assert property (@(posedge clk) disable iff (!rst_n)
        p2_v == p1_v - {1'b0, ~p1_g} - {{M{1'b0}}, p1_c});

    p_pass_keeps_g_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_g == f_g) && (p2_g == ~p1_g));

endmodule

bind inc_borrow_incr inc_borrow_incr_chk #(.M(M)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .v_in   (v_in),
    .c_in   (c_in),
    .g_in   (g_in),
    .v_out  (v_out),
    .c_out  (c_out),
    .g_out  (g_out),
    .s_flip (s_flip),
    .s_pass1(s_pass1),
    .s_pass2(s_pass2)
);

// File: tb/test_inc_borrow_incr.sv
module test_inc_borrow_incr;

    localparam int M  = 4;
    localparam int VN = 1 << (M + 1);
    localparam int GN = 1 << M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [M:0]   v_in = '0;
    logic         c_in = 1'b0;
    logic [M-1:0] g_in = '0;
    logic [M:0]   v_out;
    logic         c_out;
    logic [M-1:0] g_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    inc_borrow_incr #(.M(M)) i_inc_borrow_incr (
        .clk  (clk),
        .rst_n(rst_n),
        .v_in (v_in),
        .c_in (c_in),
        .g_in (g_in),
        .v_out(v_out),
        .c_out(c_out),
        .g_out(g_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int v, input int c, input int g);
        @(negedge clk);
        v_in = (M+1)'(v);
        c_in = c[0];
        g_in = M'(g);
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [M:0] ref_g0;
        logic [M:0] res_c0 [GN];
        #1 rst_n = 1'b0;
        v_in = '1; c_in = 1'b1; g_in = '1;
        repeat (2) @(posedge clk);
        #1;
        // R7: outputs cleared during reset
        check("R7 v_out in reset", int'(v_out), 0);
        check("R7 c_out/g_out in reset", int'({c_out, g_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        ref_g0 = '0;
        for (int v = 0; v < VN; v++) begin
            for (int c = 0; c < 2; c++) begin
                for (int g = 0; g < GN; g++) begin
                    apply(v, c, g);
                    check("R1 increment", int'(v_out), (v + 1) % VN);
                    check("R2 carry restored", int'(c_out), c);
                    check("R3 scratch restored", int'(g_out), g);
                    if (v == VN - 1) check("R4 wrap to zero", int'(v_out), 0);
                    if (c == 0 && g == 0) ref_g0 = v_out;
                    check("R6 scratch independence", int'(v_out), int'(ref_g0));
                    if (c == 0) res_c0[g] = v_out;
                    else check("R5 carry independence", int'(v_out), int'(res_c0[g]));
                end
            end
        end

        // R7: asynchronous clear between edges, with busy inputs
        apply(5, 1, 9);
        #0.5 rst_n = 1'b0;
        #0.5;
        check("R7 async clear v_out", int'(v_out), 0);
        check("R7 async clear c_out/g_out", int'({c_out, g_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(VN - 1, 1, GN - 1);
        check("R4 wrap after reset", int'(v_out), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule